// File: doc/BRIEF.md
# Power-On Sequencer Controller

This block is the digital controller that brings a group of voltage regulators (a set of LDOs and a set of buck converters) up in a fixed order after a power-on event. A power-on event is a rising edge on the charger-present input, or a key press when key turn-on is permitted. A single millisecond counter then runs up to a selectable reset delay. Each regulator's enable is released at a configured fraction of that delay. When the delay has elapsed, the active-low reset output is released.

Each regulator has a 3-bit slot code. The code either places the regulator at a point in the sequence, keeps it off until a command enables it after reset release, or (for LDOs only) makes it always-on whenever the system or battery supply is present. Each buck converter is modelled with a blanking interval after its enable, and a ramp indication is raised when that interval ends.

An undervoltage flag on the system supply is policed throughout. With no charger present, it sends the controller straight to off. With a charger present during sequencing, it either shuts everything down until the charger is removed, or pauses the sequence with the counter frozen and re-checks the flag at a fixed retry period.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: The reset delay in `ms_tick` pulses is 80 for `dly_sel`=00, 120 for 01, 220 for 10 and 420 for 11. `rst_out_n` goes high after the delay-th tick following the start, and not before.
- R2: Slot code 001 enables its regulator as soon as sequencing starts. Code 010 enables it once delay>>2 ticks have been counted, code 011 once delay>>1 ticks have been counted, and code 100 on the tick that releases reset.
- R3: Slot code 000, as well as the unused codes 101 and 110 (and 111 on a buck), keeps the regulator off while reset is held. After release, such a regulator follows its command bit (`ldo_cmd` or `buck_cmd`).
- R4: An LDO with slot code 111 has its enable equal to `supply_ok` in every controller state, including off and shutdown.
- R5: `buck_ramp` of a buck rises after its enable has been high for 8 ticks. It is low whenever that enable is low.
- R6: Sequencing starts only on a rising edge of `chg_present`, or on `key_press` while `key_on_allow` is 1. Ticks alone leave the block off.
- R7: `uv_flag` high with `chg_present` low, in any powered state, returns the block to off in the next cycle. All non-always-on enables then drop and reset is held.
- R8: `uv_flag` high during sequencing with a charger present and `retry_cfg`=0 drops `sys_en`, all non-always-on enables and reset until `chg_present` falls. The block is then off, and a new charger insertion starts it again.
- R9: With `retry_cfg`=1, the same condition pauses the sequence. The counter is frozen, enables already on stay on and `sys_en` stays high. The flag is re-checked every 500 ticks, and sequencing resumes from the frozen count only once the flag is clear at a re-check.
- R10: `sys_en` is high exactly while the block is sequencing, paused for retry or running with reset released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| dly_sel | input | 2 | Reset delay select |
| key_on_allow | input | 1 | Permits key-press turn-on |
| retry_cfg | input | 1 | Undervoltage policy: 0 shut down, 1 retry |
| ldo_slot | input | 3*N_LDO | Slot codes of the LDOs, LDO i at bits 3i+2:3i |
| buck_slot | input | 3*N_BUCK | Slot codes of the bucks, buck i at bits 3i+2:3i |
| ldo_cmd | input | N_LDO | Command enables for LDOs |
| buck_cmd | input | N_BUCK | Command enables for bucks |
| supply_ok | input | 1 | System or battery supply present |
| uv_flag | input | 1 | System supply undervoltage |
| chg_present | input | 1 | Valid charger input |
| key_press | input | 1 | Key press event |
| sys_en | output | 1 | System supply switch enable |
| ldo_en | output | N_LDO | LDO enables |
| buck_en | output | N_BUCK | Buck enables |
| buck_ramp | output | N_BUCK | Buck blanking finished, output ramping |
| rst_out_n | output | 1 | Active-low reset output |

## Verification
The assertions assume that `ms_tick` is a single-cycle pulse and that `dly_sel` does not change while a sequence is in progress. The frozen-counter and hold checks rely on this, because a changing delay would move thresholds under an already enabled regulator. The bench picks a random delay, random slot codes and random command bits for each trial, but writes them only while the block is off. It pulses the tick for exactly one clock with idle clocks between pulses, and it changes the undervoltage and charger inputs only between ticks.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   localparam int DLY_A_MS = 80;
   localparam int DLY_B_MS = 120;
   localparam int DLY_C_MS = 220;
   localparam int DLY_D_MS = 420;
   localparam int CNT_W    = $clog2(DLY_D_MS + 1);

   localparam logic [2:0] SLOT_OFF = 3'b000;
   localparam logic [2:0] SLOT_P0  = 3'b001;
   localparam logic [2:0] SLOT_P25 = 3'b010;
   localparam logic [2:0] SLOT_P50 = 3'b011;
   localparam logic [2:0] SLOT_END = 3'b100;
   localparam logic [2:0] SLOT_AON = 3'b111;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_SEQ,
      ST_RETRY,
      ST_SHUT,
      ST_RUN
   } seq_state_t;

   function automatic logic [CNT_W-1:0] delay_of(input logic [1:0] sel);
      case (sel)
         2'd0:    delay_of = CNT_W'(DLY_A_MS);
         2'd1:    delay_of = CNT_W'(DLY_B_MS);
         2'd2:    delay_of = CNT_W'(DLY_C_MS);
         default: delay_of = CNT_W'(DLY_D_MS);
      endcase
   endfunction

endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
   import pwr_seq_pkg::*;
#(
   parameter int RETRY_MS = 500
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic [1:0]       dly_sel,
   input  logic             key_on_allow,
   input  logic             retry_cfg,
   input  logic             uv_flag,
   input  logic             chg_present,
   input  logic             key_press,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] delay,
   output logic             active,
   output logic             released,
   output logic             sys_en
);
   localparam int RW = (RETRY_MS > 1) ? $clog2(RETRY_MS) : 1;

   initial begin
      assert (RETRY_MS >= 2) else $error("RETRY_MS must be at least 2");
   end

   seq_state_t      state;
   logic            chg_q;
   logic [RW-1:0]   rcnt;
   logic            start;

   assign delay    = delay_of(dly_sel);
   assign start    = (chg_present && !chg_q) || (key_press && key_on_allow);
   assign active   = (state == ST_SEQ) || (state == ST_RETRY) || (state == ST_RUN);
   assign released = (state == ST_RUN);
   assign sys_en   = active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_OFF;
         chg_q <= 1'b0;
         count <= '0;
         rcnt  <= '0;
      end else begin
         chg_q <= chg_present;
         unique case (state)
            ST_OFF: begin
               if (start) begin
                  state <= ST_SEQ;
                  count <= '0;
               end
            end
            ST_SEQ: begin
               if (uv_flag) begin
                  rcnt <= '0;
                  if (!chg_present)  state <= ST_OFF;
                  else if (retry_cfg) state <= ST_RETRY;
                  else               state <= ST_SHUT;
               end else if (ms_tick) begin
                  count <= count + 1'b1;
                  if (count == delay - 1'b1) state <= ST_RUN;
               end
            end
            ST_RETRY: begin
               if (!chg_present) begin
                  state <= ST_OFF;
               end else if (ms_tick) begin
                  if (rcnt == RW'(RETRY_MS - 1)) begin
                     rcnt <= '0;
                     if (!uv_flag) state <= ST_SEQ;
                  end else begin
                     rcnt <= rcnt + 1'b1;
                  end
               end
            end
            ST_SHUT: begin
               if (!chg_present) state <= ST_OFF;
            end
            ST_RUN: begin
               if (uv_flag && !chg_present) state <= ST_OFF;
            end
            default: state <= ST_OFF;
         endcase
      end
   end

   assert_uv_nochg_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_OFF && uv_flag && !chg_present) |=> (state == ST_OFF));

   assert_shut_policy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEQ && uv_flag && chg_present && !retry_cfg) |=> (state == ST_SHUT));

   assert_retry_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RETRY && $past(state == ST_RETRY)) |-> $stable(count));

   assert_release_at_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(released) |-> (count == delay));

   assert_sys_with_rst_R10: assert property (@(posedge clk) disable iff (!rst_n)
      released |-> sys_en);

endmodule

// File: rtl/seq_slot.sv
module seq_slot
   import pwr_seq_pkg::*;
#(
   parameter bit IS_LDO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       code,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] delay,
   input  logic             active,
   input  logic             released,
   input  logic             cmd,
   input  logic             supply_ok,
   output logic             en
);
   logic [CNT_W-1:0] thr_q, thr_h;
   logic             by_cmd;

   assign thr_q  = delay >> 2;
   assign thr_h  = delay >> 1;
   assign by_cmd = released && cmd;

   generate
      if (IS_LDO) begin : g_ldo
         always_comb begin
            case (code)
               SLOT_P0:  en = active;
               SLOT_P25: en = active && (count >= thr_q);
               SLOT_P50: en = active && (count >= thr_h);
               SLOT_END: en = released;
               SLOT_AON: en = supply_ok;
               default:  en = by_cmd;
            endcase
         end
      end else begin : g_buck
         always_comb begin
            case (code)
               SLOT_P0:  en = active;
               SLOT_P25: en = active && (count >= thr_q);
               SLOT_P50: en = active && (count >= thr_h);
               SLOT_END: en = released;
               default:  en = by_cmd;
            endcase
         end
      end
   endgenerate

   assert_off_until_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!released && code == SLOT_OFF) |-> !en);

   assert_seq_needs_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && code != SLOT_AON) |-> !en);

endmodule

// File: rtl/buck_blank.sv
module buck_blank
#(
   parameter int BLANK_MS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic en,
   output logic ramp
);
   localparam int BW = $clog2(BLANK_MS + 1);

   initial begin
      assert (BLANK_MS >= 1) else $error("BLANK_MS must be at least 1");
   end

   logic [BW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt <= '0;
      else if (!en)                              cnt <= '0;
      else if (ms_tick && cnt != BW'(BLANK_MS))  cnt <= cnt + 1'b1;
   end

   assign ramp = en && (cnt == BW'(BLANK_MS));

   assert_ramp_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ramp |-> en);

   assert_ramp_not_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> !ramp);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
   import pwr_seq_pkg::*;
#(
   parameter int N_LDO    = 3,
   parameter int N_BUCK   = 2,
   parameter int BLANK_MS = 8,
   parameter int RETRY_MS = 500
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ms_tick,
   input  logic [1:0]            dly_sel,
   input  logic                  key_on_allow,
   input  logic                  retry_cfg,
   input  logic [3*N_LDO-1:0]    ldo_slot,
   input  logic [3*N_BUCK-1:0]   buck_slot,
   input  logic [N_LDO-1:0]      ldo_cmd,
   input  logic [N_BUCK-1:0]     buck_cmd,
   input  logic                  supply_ok,
   input  logic                  uv_flag,
   input  logic                  chg_present,
   input  logic                  key_press,
   output logic                  sys_en,
   output logic [N_LDO-1:0]      ldo_en,
   output logic [N_BUCK-1:0]     buck_en,
   output logic [N_BUCK-1:0]     buck_ramp,
   output logic                  rst_out_n
);
   initial begin
      assert (N_LDO >= 1 && N_BUCK >= 1) else $error("need at least one LDO and one buck");
   end

   logic [CNT_W-1:0] count, delay;
   logic             active, released;

   pwr_seq_fsm #(.RETRY_MS(RETRY_MS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .dly_sel(dly_sel),
      .key_on_allow(key_on_allow), .retry_cfg(retry_cfg), .uv_flag(uv_flag),
      .chg_present(chg_present), .key_press(key_press), .count(count),
      .delay(delay), .active(active), .released(released), .sys_en(sys_en)
   );

   assign rst_out_n = released;

   for (genvar i = 0; i < N_LDO; i++) begin : g_ldo
      seq_slot #(.IS_LDO(1'b1)) u_slot (
         .clk(clk), .rst_n(rst_n), .code(ldo_slot[3*i +: 3]), .count(count),
         .delay(delay), .active(active), .released(released), .cmd(ldo_cmd[i]),
         .supply_ok(supply_ok), .en(ldo_en[i])
      );
   end

   for (genvar j = 0; j < N_BUCK; j++) begin : g_buck
      seq_slot #(.IS_LDO(1'b0)) u_slot (
         .clk(clk), .rst_n(rst_n), .code(buck_slot[3*j +: 3]), .count(count),
         .delay(delay), .active(active), .released(released), .cmd(buck_cmd[j]),
         .supply_ok(supply_ok), .en(buck_en[j])
      );
      buck_blank #(.BLANK_MS(BLANK_MS)) u_blank (
         .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .en(buck_en[j]),
         .ramp(buck_ramp[j])
      );
   end

   assert_aon_tracks_supply_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ldo_slot[2:0] == SLOT_AON) |-> (ldo_en[0] == supply_ok));

   assert_reset_only_powered_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_en |-> !rst_out_n);

endmodule

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
   localparam int NL = 3;
   localparam int NB = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_tick = 1'b0;
   logic [1:0] dly_sel = 2'd0;
   logic key_on_allow = 1'b0;
   logic retry_cfg = 1'b0;
   logic [3*NL-1:0] ldo_slot = '0;
   logic [3*NB-1:0] buck_slot = '0;
   logic [NL-1:0] ldo_cmd = '0;
   logic [NB-1:0] buck_cmd = '0;
   logic supply_ok = 1'b1;
   logic uv_flag = 1'b0;
   logic chg_present = 1'b0;
   logic key_press = 1'b0;
   logic sys_en, rst_out_n;
   logic [NL-1:0] ldo_en;
   logic [NB-1:0] buck_en, buck_ramp;

   int checks = 0;
   int errors = 0;

   pwr_seq_ctrl #(.N_LDO(NL), .N_BUCK(NB)) uut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .dly_sel(dly_sel),
      .key_on_allow(key_on_allow), .retry_cfg(retry_cfg), .ldo_slot(ldo_slot),
      .buck_slot(buck_slot), .ldo_cmd(ldo_cmd), .buck_cmd(buck_cmd),
      .supply_ok(supply_ok), .uv_flag(uv_flag), .chg_present(chg_present),
      .key_press(key_press), .sys_en(sys_en), .ldo_en(ldo_en), .buck_en(buck_en),
      .buck_ramp(buck_ramp), .rst_out_n(rst_out_n)
   );

   always #5 clk = ~clk;

   task automatic check(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int delay_b(input logic [1:0] s);
      case (s)
         2'd0: return 80;
         2'd1: return 120;
         2'd2: return 220;
         default: return 420;
      endcase
   endfunction

   // tick index at which a sequenced or commanded regulator turns on; -1 never
   function automatic int ken_of(input logic [2:0] c, input bit ldo, input bit cmd, input int t);
      case (c)
         3'b001: return 0;
         3'b010: return t >> 2;
         3'b011: return t >> 1;
         3'b100: return t;
         3'b111: if (ldo) return -2;
                 else return cmd ? t : -1;
         default: return cmd ? t : -1;
      endcase
   endfunction

   function automatic logic [NL-1:0] exp_ldo(input int k, input int t);
      logic [NL-1:0] v;
      for (int i = 0; i < NL; i++) begin
         int ke = ken_of(ldo_slot[3*i +: 3], 1'b1, ldo_cmd[i], t);
         if (ke == -2) v[i] = supply_ok;
         else          v[i] = (ke >= 0) && (k >= ke);
      end
      return v;
   endfunction

   function automatic logic [NB-1:0] exp_buck(input int k, input int t, input bit ramp);
      logic [NB-1:0] v;
      for (int i = 0; i < NB; i++) begin
         int ke = ken_of(buck_slot[3*i +: 3], 1'b0, buck_cmd[i], t);
         v[i] = (ke >= 0) && (k >= ke + (ramp ? 8 : 0));
      end
      return v;
   endfunction

   function automatic logic [NL-1:0] aon_mask();
      logic [NL-1:0] v;
      for (int i = 0; i < NL; i++) v[i] = (ldo_slot[3*i +: 3] == 3'b111) && supply_ok;
      return v;
   endfunction

   task automatic tick();
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog run did not complete");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      ldo_slot = {3'b010, 3'b001, 3'b111};
      idle(3);
      check("R10", "sys_en in reset", sys_en, 1'b0);
      check("R1", "rst_out_n in reset", rst_out_n, 1'b0);
      check("R4", "always-on LDO in reset", ldo_en, 3'b001);
      rst_n = 1'b1;
      idle(2);

      // R6: ticks and key press without permission do not start
      ticks(5);
      key_press = 1'b1; idle(1); key_press = 1'b0; idle(2);
      check("R6", "sys_en no start", sys_en, 1'b0);
      check("R6", "ldo_en no start", ldo_en, 3'b001);
      supply_ok = 1'b0; idle(1);
      check("R4", "always-on LDO follows supply", ldo_en, 3'b000);
      supply_ok = 1'b1; idle(1);

      // random trials
      for (int tr = 0; tr < 12; tr++) begin
         int t;
         bit use_key;
         dly_sel   = 2'($urandom_range(0, 3));
         ldo_slot  = 9'($urandom);
         buck_slot = 6'($urandom);
         ldo_cmd   = 3'($urandom);
         buck_cmd  = 2'($urandom);
         use_key   = bit'($urandom_range(0, 1));
         t = delay_b(dly_sel);
         idle(1);
         if (use_key) begin
            key_on_allow = 1'b1; key_press = 1'b1; idle(1);
            key_press = 1'b0; key_on_allow = 1'b0;
         end else begin
            chg_present = 1'b1; idle(1);
         end
         idle(1);
         check("R6", "start sys_en", sys_en, 1'b1);
         check("R2", "ldo at start", ldo_en, exp_ldo(0, t));
         for (int k = 1; k <= t + 10; k++) begin
            tick();
            check("R2", $sformatf("ldo_en k=%0d", k), ldo_en, exp_ldo(k, t));
            check("R3", $sformatf("buck_en k=%0d", k), buck_en, exp_buck(k, t, 1'b0));
            check("R5", $sformatf("buck_ramp k=%0d", k), buck_ramp, exp_buck(k, t, 1'b1));
            check("R1", $sformatf("rst_out_n k=%0d", k), rst_out_n, k >= t);
            check("R10", $sformatf("sys_en k=%0d", k), sys_en, 1'b1);
         end
         chg_present = 1'b0; idle(1);
         uv_flag = 1'b1; idle(1); uv_flag = 1'b0; idle(1);
         check("R7", "off sys_en", sys_en, 1'b0);
         check("R7", "off rst", rst_out_n, 1'b0);
         check("R7", "off ldo", ldo_en, aon_mask());
         check("R7", "off buck", buck_en, 2'b00);
         check("R5", "off ramp", buck_ramp, 2'b00);
      end

      // R8: shutdown policy
      dly_sel = 2'd0; retry_cfg = 1'b0;
      ldo_slot = {3'b100, 3'b010, 3'b111}; buck_slot = {3'b000, 3'b001};
      ldo_cmd = '1; buck_cmd = '1;
      chg_present = 1'b1; idle(2);
      ticks(30);
      check("R2", "25pct slot on at 30", ldo_en, 3'b011);
      uv_flag = 1'b1; idle(2);
      check("R8", "shut sys_en", sys_en, 1'b0);
      check("R8", "shut ldo", ldo_en, 3'b001);
      check("R8", "shut buck", buck_en, 2'b00);
      uv_flag = 1'b0; ticks(100);
      check("R8", "still shut", {sys_en, rst_out_n}, 2'b00);
      chg_present = 1'b0; idle(2);
      check("R8", "off after removal", sys_en, 1'b0);
      chg_present = 1'b1; idle(2);
      check("R8", "restart on insertion", sys_en, 1'b1);
      check("R8", "restart count zero", ldo_en, 3'b001);

      // R9: retry policy (power down first)
      chg_present = 1'b0; uv_flag = 1'b1; idle(1); uv_flag = 1'b0; idle(1);
      retry_cfg = 1'b1;
      ldo_slot = {3'b100, 3'b011, 3'b010}; buck_slot = {3'b000, 3'b001};
      chg_present = 1'b1; idle(2);
      ticks(30);
      check("R2", "before pause", ldo_en, 3'b001);
      uv_flag = 1'b1; idle(2);
      ticks(499);
      check("R9", "paused enables held", ldo_en, 3'b001);
      check("R9", "paused sys_en", {sys_en, rst_out_n}, 2'b10);
      tick();
      uv_flag = 1'b0;
      ticks(499);
      check("R9", "no resume before recheck", ldo_en, 3'b001);
      tick();
      ticks(9);
      check("R9", "resumed frozen count 39", ldo_en, 3'b001);
      tick();
      check("R9", "resumed 50pct at 40", ldo_en, 3'b011);
      ticks(39);
      check("R1", "no release at 79", rst_out_n, 1'b0);
      tick();
      check("R1", "release at 80", rst_out_n, 1'b1);
      check("R2", "end slot at release", ldo_en, 3'b111);

      summary();
      $finish;
   end
endmodule